// File: doc/BRIEF.md
# Protection Rule Configuration Register File

This block holds the configuration of a set of memory protection rules: one configuration byte and one address register per rule, plus a small global security register. Software-style writes arrive as a register select, an index, a data word and byte strobes. Each target byte is checked against lock, lockdown and encoding rules. A byte that would break a rule is dropped whole. All other bytes commit. The committed state is driven out to a downstream access checker and can also be read back through a registered read port. This lets software compare what it wrote with what was kept.

The security register has three bits. The first is a sticky machine lockdown bit. The second is a sticky deny-by-default bit. The third is a rule-lock bypass bit. While the bypass bit is set, locked rules stay editable during boot. Once any locked rule exists with the bypass bit clear, the bypass bit can no longer be set.

Every register loads its value from a module parameter on reset. This includes rules with lockdown already active that could not be written later.

Top module: `prot_cfg_regs`

## Requirements
- R1: A configuration byte whose lock bit (bit 7) is 1 ignores writes while the bypass bit is 0. The address register of the same entry also ignores writes while the bypass bit is 0.
- R2: While the bypass bit is 1, locked configuration bytes and their address registers can be rewritten or cleared.
- R3: The security register layout is: bit 0 = lockdown, bit 1 = deny-by-default, bit 2 = bypass. A write that sets the bypass bit is ignored when the bypass bit is 0 and any entry has its lock bit set. A write that clears the bypass bit always takes effect.
- R4: While lockdown is 1 and bypass is 0, a configuration byte write is rejected in either of two cases: (a) lock=1 with X (bit 2) = 1, except when R, W and X are all 1; (b) lock=1 with R (bit 0) = 0 and W (bit 1) = 1. Unlocked executable bytes are accepted.
- R5: While lockdown is 0, a configuration byte write with R=0 and W=1 is rejected, and the old byte is kept.
- R6: On reset, every configuration byte, address register and the security register take their values from parameters. This holds even when those values include lockdown set together with a locked executable shared rule.
- R7: Configuration bytes are packed 4 per 32-bit word, with entry 4·w+b in byte b of word w. Each byte is committed or rejected independently under its own strobe. A write with a clear strobe leaves that byte unchanged. Address writes honour per-byte strobes.
- R8: Once set, the lockdown and deny-by-default bits stay 1 until reset. Writing 0 to them has no effect.
- R9: Bits 6:5 of every committed configuration byte are stored as 0.
- R10: The read port returns the committed value one clock after the select is applied. The select is 0 = configuration word, 1 = address register, 2 = security register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Write target kind (0 config word, 1 address, 2 security) |
| wr_idx | input | IDX_W | Config word index or address entry index |
| wr_data | input | DATA_W | Write data |
| wr_strb | input | DATA_W/8 | Byte strobes |
| rd_sel | input | 2 | Read target kind |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | DATA_W | Registered read data |
| cfg_o | output | N_ENTRY*8 | All committed configuration bytes |
| addr_o | output | N_ENTRY*AW | All committed address registers |
| sec_o | output | 3 | Committed security register |

## Verification
The write filter is exercised in three states: no lock and no lockdown, a locked entry with and without bypass, and lockdown active. One mixed word places a machine-executable byte, the all-permission shared byte, a locked shared-code byte and an unlocked shared-data byte side by side. This separates per-byte rejection from whole-word rejection. The bypass bit is set before any lock exists and then re-set after a lock exists, which distinguishes the lockout from a plain write failure. A second instance with lockdown and a locked shared-code rule in its reset parameters shows that reset values bypass the write filter.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2
  } reg_sel_e;

  localparam int B_R = 0;
  localparam int B_W = 1;
  localparam int B_X = 2;
  localparam int B_L = 7;

  localparam int S_LOCKDOWN = 0;
  localparam int S_DENYDEF  = 1;
  localparam int S_BYPASS   = 2;

  localparam logic [7:0] CFG_KEEP_MASK = 8'h9F;

  // R=0,W=1 combination
  function automatic logic rw_shared(input logic [7:0] c);
    return !c[B_R] && c[B_W];
  endfunction

  // locked rule executable in machine mode (all-ones shared read-only excluded)
  function automatic logic locked_exec(input logic [7:0] c);
    return c[B_L] && ((c[B_X] && !(c[B_R] && c[B_W])) || rw_shared(c));
  endfunction

endpackage

// File: rtl/prot_sec_ctrl.sv
module prot_sec_ctrl
  import prot_cfg_pkg::*;
#(
  parameter logic [2:0] RST_SEC = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] wdata,
  input  logic       any_locked_i,
  output logic [2:0] sec_q
);

  logic bypass_ok;
  assign bypass_ok = sec_q[S_BYPASS] || !any_locked_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= RST_SEC;
    end else if (we) begin
      sec_q[S_LOCKDOWN] <= sec_q[S_LOCKDOWN] | wdata[S_LOCKDOWN];
      sec_q[S_DENYDEF]  <= sec_q[S_DENYDEF]  | wdata[S_DENYDEF];
      sec_q[S_BYPASS]   <= wdata[S_BYPASS] && bypass_ok;
    end
  end

  // R3: bypass cannot rise once a lock exists while it is clear
  a_r3_bypass_lockout: assert property (@(posedge clk) disable iff (rst)
    (!sec_q[S_BYPASS] && any_locked_i) |=> !sec_q[S_BYPASS]);

  // R8: sticky bits
  a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (rst)
    sec_q[S_LOCKDOWN] |=> sec_q[S_LOCKDOWN]);
  a_r8_denydef_sticky: assert property (@(posedge clk) disable iff (rst)
    sec_q[S_DENYDEF] |=> sec_q[S_DENYDEF]);

endmodule

// File: rtl/prot_entry_slot.sv
module prot_entry_slot
  import prot_cfg_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [7:0]  RST_CFG  = 8'h00,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  input  logic            addr_we,
  input  logic [AW-1:0]   addr_wdata,
  input  logic [AW/8-1:0] addr_wstrb,
  input  logic            lockdown_i,
  input  logic            bypass_i,
  output logic [7:0]      cfg_q,
  output logic [AW-1:0]   addr_q
);

  localparam int AB = AW / 8;

  logic       editable;
  logic [7:0] cand;
  logic       legal;

  assign editable = !cfg_q[B_L] || bypass_i;
  assign cand     = cfg_wdata & CFG_KEEP_MASK;

  always_comb begin
    if (lockdown_i) legal = editable && !(locked_exec(cand) && !bypass_i);
    else            legal = editable && !rw_shared(cand);
  end

  always_ff @(posedge clk) begin
    if (rst)                  cfg_q <= RST_CFG & CFG_KEEP_MASK;
    else if (cfg_we && legal) cfg_q <= cand;
  end

  for (genvar b = 0; b < AB; b++) begin : g_abyte
    always_ff @(posedge clk) begin
      if (rst)
        addr_q[b*8 +: 8] <= RST_ADDR[b*8 +: 8];
      else if (addr_we && addr_wstrb[b] && editable)
        addr_q[b*8 +: 8] <= addr_wdata[b*8 +: 8];
    end
  end

  // R1: locked entry without bypass holds
  a_r1_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[B_L] && !bypass_i) |=> ($stable(cfg_q) && $stable(addr_q)));

  // R4: no new locked executable rule under lockdown without bypass
  a_r4_no_new_exec: assert property (@(posedge clk) disable iff (rst)
    (lockdown_i && !bypass_i && !cfg_q[B_L]) |=> !locked_exec(cfg_q));

  // R5: reserved combination never created while lockdown is off
  a_r5_no_reserved: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !lockdown_i && !rw_shared(cfg_q)) |=> !rw_shared(cfg_q));

  // R9: reserved bits stay zero
  a_r9_resv_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_q[6:5] == 2'b00));

endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_cfg_pkg::*;
#(
  parameter int                    N_ENTRY  = 8,
  parameter int                    DATA_W   = 32,
  parameter int                    AW       = 32,
  parameter logic [N_ENTRY*8-1:0]  RST_CFG  = '0,
  parameter logic [N_ENTRY*AW-1:0] RST_ADDR = '0,
  parameter logic [2:0]            RST_SEC  = 3'b000,
  localparam int                   BPW      = DATA_W / 8,
  localparam int                   IDX_W    = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [BPW-1:0]        wr_strb,
  input  logic [1:0]            rd_sel,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [DATA_W-1:0]     rd_data,
  output logic [N_ENTRY*8-1:0]  cfg_o,
  output logic [N_ENTRY*AW-1:0] addr_o,
  output logic [2:0]            sec_o
);

  localparam int N_WORD = N_ENTRY / BPW;

  logic any_locked;
  logic sec_we;

  always_comb begin
    any_locked = 1'b0;
    for (int i = 0; i < N_ENTRY; i++) any_locked |= cfg_o[i*8 + B_L];
  end

  assign sec_we = wr_en && (wr_sel == SEL_SEC) && wr_strb[0];

  prot_sec_ctrl #(.RST_SEC(RST_SEC)) u_sec (
    .clk          (clk),
    .rst          (rst),
    .we           (sec_we),
    .wdata        (wr_data[2:0]),
    .any_locked_i (any_locked),
    .sec_q        (sec_o)
  );

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    logic cfg_we_i;
    logic addr_we_i;
    assign cfg_we_i  = wr_en && (wr_sel == SEL_CFG) &&
                       (wr_idx == IDX_W'(i / BPW)) && wr_strb[i % BPW];
    assign addr_we_i = wr_en && (wr_sel == SEL_ADDR) && (wr_idx == IDX_W'(i));

    prot_entry_slot #(
      .AW       (AW),
      .RST_CFG  (RST_CFG[i*8 +: 8]),
      .RST_ADDR (RST_ADDR[i*AW +: AW])
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (cfg_we_i),
      .cfg_wdata  (wr_data[(i % BPW)*8 +: 8]),
      .addr_we    (addr_we_i),
      .addr_wdata (wr_data[AW-1:0]),
      .addr_wstrb (wr_strb[AW/8-1:0]),
      .lockdown_i (sec_o[S_LOCKDOWN]),
      .bypass_i   (sec_o[S_BYPASS]),
      .cfg_q      (cfg_o[i*8 +: 8]),
      .addr_q     (addr_o[i*AW +: AW])
    );
  end

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rd_sel == SEL_CFG) begin
      for (int w = 0; w < N_WORD; w++)
        if (rd_idx == IDX_W'(w)) rd_next = cfg_o[w*DATA_W +: DATA_W];
    end else if (rd_sel == SEL_ADDR) begin
      for (int i = 0; i < N_ENTRY; i++)
        if (rd_idx == IDX_W'(i)) rd_next = DATA_W'(addr_o[i*AW +: AW]);
    end else if (rd_sel == SEL_SEC) begin
      rd_next = DATA_W'(sec_o);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R10: a security read reflects the committed register one clock later
  a_r10_sec_read: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_SEC) |=> (rd_data == DATA_W'($past(sec_o))));

endmodule

// File: tb/sim_prot_cfg_regs.sv
module sim_prot_cfg_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic [1:0]  sel;
    logic [2:0]  idx;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // walked in order; state carries from one vector to the next
  localparam vec_t VEC [NV] = '{
    '{2'd2, 3'd0, 32'h0000_0004, 4'h1, 32'h0000_0004, 4'd3},  // R3 set bypass, no lock yet
    '{2'd0, 3'd0, 32'h0000_0203, 4'h3, 32'h0000_0003, 4'd5},  // R5 byte1 R=0,W=1 dropped
    '{2'd0, 3'd0, 32'h0000_0065, 4'h1, 32'h0000_0005, 4'd9},  // R9 bits 6:5 cleared
    '{2'd0, 3'd0, 32'h0000_8100, 4'h2, 32'h0000_8105, 4'd7},  // R7 lock entry1
    '{2'd0, 3'd0, 32'h0000_8300, 4'h2, 32'h0000_8305, 4'd2},  // R2 edit locked via bypass
    '{2'd1, 3'd1, 32'h0000_1234, 4'hF, 32'h0000_1234, 4'd2},  // R2 addr of locked entry
    '{2'd2, 3'd0, 32'h0000_0000, 4'h1, 32'h0000_0000, 4'd3},  // R3 clear bypass
    '{2'd2, 3'd0, 32'h0000_0004, 4'h1, 32'h0000_0000, 4'd3},  // R3 re-set refused
    '{2'd0, 3'd0, 32'h0000_0000, 4'h2, 32'h0000_8305, 4'd1},  // R1 locked cfg holds
    '{2'd1, 3'd1, 32'h0000_FFFF, 4'hF, 32'h0000_1234, 4'd1},  // R1 locked addr holds
    '{2'd1, 3'd0, 32'h0000_ABCD, 4'hF, 32'h0000_ABCD, 4'd7},  // R7 unlocked addr
    '{2'd1, 3'd0, 32'hFFFF_FF11, 4'h1, 32'h0000_AB11, 4'd7},  // R7 addr byte strobe
    '{2'd2, 3'd0, 32'h0000_0001, 4'h1, 32'h0000_0001, 4'd8},  // R8 lockdown on
    '{2'd2, 3'd0, 32'h0000_0000, 4'h1, 32'h0000_0001, 4'd8},  // R8 lockdown sticky
    '{2'd0, 3'd1, 32'h0282_8785, 4'hF, 32'h0200_8700, 4'd4},  // R4 mixed word
    '{2'd0, 3'd1, 32'h0000_0004, 4'h1, 32'h0200_8704, 4'd4},  // R4 unlocked exec ok
    '{2'd0, 3'd1, 32'hFFFF_FFFF, 4'h0, 32'h0200_8704, 4'd7},  // R7 no strobe, no change
    '{2'd2, 3'd0, 32'h0000_0002, 4'h1, 32'h0000_0003, 4'd8},  // R8 deny-default on
    '{2'd2, 3'd0, 32'h0000_0000, 4'h1, 32'h0000_0003, 4'd8}   // R8 deny-default sticky
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic [1:0]  rd_sel = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [63:0] cfg_o;
  logic [255:0] addr_o;
  logic [2:0]  sec_o;

  logic [31:0]  rd_data1;
  logic [63:0]  cfg_o1;
  logic [255:0] addr_o1;
  logic [2:0]   sec_o1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_cfg_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_sel(rd_sel), .rd_idx(rd_idx),
    .rd_data(rd_data), .cfg_o(cfg_o), .addr_o(addr_o), .sec_o(sec_o)
  );

  // reset-programmed lockdown plus locked executable shared-code rule at entry 0
  prot_cfg_regs #(
    .RST_CFG  (64'h0000_0000_0000_0086),
    .RST_ADDR ({224'd0, 32'h0000_4000}),
    .RST_SEC  (3'b001)
  ) u1 (
    .clk(clk), .rst(rst), .wr_en(1'b0), .wr_sel(2'd0), .wr_idx(3'd0),
    .wr_data(32'd0), .wr_strb(4'd0), .rd_sel(2'd0), .rd_idx(3'd0),
    .rd_data(rd_data1), .cfg_o(cfg_o1), .addr_o(addr_o1), .sec_o(sec_o1)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // reset state, R6 and R10
    check("R6 u0 cfg reset", cfg_o, 64'd0);
    check("R6 u0 addr reset", 64'(addr_o), 64'd0);
    check("R6 u0 sec reset", 64'(sec_o), 64'd0);
    check("R10 rd_data reset", 64'(rd_data), 64'd0);
    check("R6 u1 cfg reset", 64'(cfg_o1[7:0]), 64'h86);
    check("R6 u1 sec reset", 64'(sec_o1), 64'h1);
    check("R6 u1 addr reset", 64'(addr_o1[31:0]), 64'h4000);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = VEC[k].sel; wr_idx = VEC[k].idx;
      wr_data = VEC[k].data; wr_strb = VEC[k].strb;
      rd_sel = VEC[k].sel; rd_idx = VEC[k].idx;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check($sformatf("R%0d vector %0d (R10 readback)", VEC[k].req, k),
            64'(rd_data), 64'(VEC[k].exp));
    end

    // directed: exposed outputs agree with the read port
    check("R4 entry4 byte via cfg_o", 64'(cfg_o[39:32]), 64'h04);
    check("R1 entry1 addr via addr_o", 64'(addr_o[63:32]), 64'h1234);

    // R6: reset mid-run restores parameter values
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    check("R6 u0 cfg after reset", cfg_o, 64'd0);
    check("R6 u0 sec after reset", 64'(sec_o), 64'd0);
    check("R6 u1 cfg after reset", 64'(cfg_o1[7:0]), 64'h86);

    // R3: after reset with no lock, bypass can be set again
    wr_en = 1'b1; wr_sel = 2'd2; wr_idx = 3'd0; wr_data = 32'h4; wr_strb = 4'h1;
    @(negedge clk) wr_en = 1'b0;
    check("R3 bypass after reset", 64'(sec_o), 64'h4);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule